// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Generator

This block converts a stream of scatter-gather segments, each a 32-bit bus address and a byte length, into the two-word descriptor entries that a bus-mastering disk controller reads from memory. The first word of each entry is the base address. The second word is a control word that carries the byte count and, in the standard format, a flag marking the final entry of the table. No entry may span a 64 KiB address window. Where a segment straddles a window edge, the block cuts it into several entries.

Two count encodings are available, chosen per table by `cfg_alt_mode`:

- The standard format stores the count in the low 16 bits of the control word. A whole 64 KiB chunk is emitted as two half-size entries, because some controllers read a zero count as zero bytes.
- The alternate format stores the number of 32-bit words minus one in the upper half of the control word. It has no end flag.

A table is built from the segments up to the one carrying `seg_last`. It is then closed with a one-cycle `tbl_done` pulse, which carries the entry count and the outcome. If generation fails, `tbl_fallback` tells software to move the request by programmed I/O instead. Generation fails when:

- the table would hold more than `MAX_ENTRIES` entries,
- a segment is misaligned, or
- the list yields no entries at all.

The controller is built around one state machine with six states:

- `ST_FETCH` takes the next segment.
  - It goes to `ST_CHUNK` for an aligned segment.
  - For a misaligned segment it goes to `ST_DRAIN`, or to `ST_REPORT` if that segment is the last one.
- `ST_CHUNK` forms one entry per cycle from the current address and remaining length.
  - It stays in `ST_CHUNK` while no earlier entry is held back.
  - It goes to `ST_EMIT_ADDR` when a held-back entry must be sent, or when the last segment is used up.
  - It goes to `ST_FETCH` when a non-final segment is used up.
  - It goes to `ST_DRAIN` or `ST_REPORT` on overflow.
  - It goes to `ST_REPORT` when the table is empty.
- `ST_EMIT_ADDR` goes to `ST_EMIT_CTRL` once the address word is taken.
- `ST_EMIT_CTRL` goes back to `ST_CHUNK` once the control word is taken, or to `ST_REPORT` if that was the final entry.
- `ST_DRAIN` swallows the segments that remain after an abort. It goes to `ST_REPORT` when the last one arrives.
- `ST_REPORT` pulses the status and always returns to `ST_FETCH`.

Top module: `prd_table_gen`

## Requirements
- R1: Each entry covers min(remaining segment bytes, 0x10000 − address[15:0]) bytes, so no entry crosses a 64 KiB boundary. The next entry starts at the previous address plus that count. Entries appear in address order through the segments.
- R2: In standard mode (`cfg_alt_mode`=0) the control word holds the byte count in bits [15:0], and bits [30:16] are zero.
- R3: In standard mode a chunk of exactly 0x10000 bytes at address A is emitted as two entries, (A, 0x8000) followed by (A+0x8000, 0x8000).
- R4: Forming entry number `MAX_ENTRIES`+1 aborts the table. `tbl_done` then reports `tbl_overflow`=1, `tbl_fallback`=1 and `tbl_entries`=`MAX_ENTRIES`. The entry held back at that moment is never sent, so `MAX_ENTRIES`−1 entries go out. Segments up to `seg_last` are still consumed.
- R5: In standard mode bit 31 of the control word is set on the final entry only. `word_last` accompanies the final control word in both modes. `tbl_done` is high in the cycle after that word is taken.
- R6: In alternate mode the control word is ((bytes>>2)−1) in bits [31:16], with bits [15:0] zero. No end bit is set, and a 0x10000 chunk stays one entry (0x3FFF0000).
- R7: A table whose segments yield no entry sends no words and finishes with `tbl_fallback`=1 and `tbl_entries`=0.
- R8: A zero-length segment is consumed and produces no entry. If the last segment has zero length, the end flag goes on the entry before it.
- R9: A segment is misaligned in standard mode if its address or length is odd, and in alternate mode if either is not a multiple of 4. A misaligned segment aborts the table: the held-back entry is dropped, `tbl_misalign`=1 and `tbl_fallback`=1, and the remaining segments up to `seg_last` are consumed.
- R10: `tbl_done` is a one-cycle pulse. While it is high, `tbl_entries` equals the number of entries formed, and each error flag reflects the table just closed.
- R11: While `word_valid` is high and `word_ready` is low, `word_data` and `word_last` hold their values.
- R12: After reset, `seg_ready` is 1 and `word_valid` and `tbl_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_alt_mode | input | 1 | Count format; sampled with the first segment of each table |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when both are high |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | 32 | Segment length in bytes |
| seg_last | input | 1 | Final segment of the table |
| word_valid | output | 1 | Descriptor word offered |
| word_ready | input | 1 | Descriptor word taken when both are high |
| word_data | output | 32 | Address word or control word |
| word_last | output | 1 | Final control word of the table |
| tbl_done | output | 1 | One-cycle pulse when the table is closed |
| tbl_fallback | output | 1 | Table failed; use programmed I/O |
| tbl_overflow | output | 1 | Table exceeded the entry limit |
| tbl_misalign | output | 1 | A segment broke the alignment rule |
| tbl_entries | output | 9 | Entries formed (width is clog2(MAX_ENTRIES+1)) |

## Verification
The assertions assume three things about the inputs:

- `cfg_alt_mode` does not change in a way that matters inside a table, because it is sampled with the first segment.
- A segment offered on `seg_valid` stays put until it is taken.
- The segment lengths leave the address from wrapping past 2^32.

The stimulus follows these rules directly. It changes the mode only between tables and holds each segment until `seg_ready` accepts it. It uses address and length pairs that stay well below the top of the address space. The stimulus also pulls `word_ready` low at random in one phase, so that the stall rule is exercised while entries are being cut.

// File: rtl/prd_pkg.sv
package prd_pkg;

    typedef enum logic [2:0] {
        ST_FETCH     = 3'd0,
        ST_CHUNK     = 3'd1,
        ST_EMIT_ADDR = 3'd2,
        ST_EMIT_CTRL = 3'd3,
        ST_DRAIN     = 3'd4,
        ST_REPORT    = 3'd5
    } prd_state_e;

endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc #(
    parameter int unsigned LEN_W    = 32,
    parameter int unsigned WIN_BITS = 16
) (
    input  logic [WIN_BITS-1:0] addr_lo,
    input  logic [LEN_W-1:0]    remain,
    input  logic                alt_fmt,
    output logic [WIN_BITS:0]   chunk
);
    localparam logic [WIN_BITS:0] WIN_SIZE  = {1'b1, {WIN_BITS{1'b0}}};
    localparam logic [WIN_BITS:0] HALF_SIZE = {2'b01, {(WIN_BITS-1){1'b0}}};

    logic [WIN_BITS:0] room;
    logic [WIN_BITS:0] full;

    always_comb begin
        room = WIN_SIZE - {1'b0, addr_lo};
        if (remain < LEN_W'(room)) begin
            full = remain[WIN_BITS:0];
        end else begin
            full = room;
        end
        if (!alt_fmt && (full == WIN_SIZE)) begin
            chunk = HALF_SIZE;
        end else begin
            chunk = full;
        end
    end

endmodule

// File: rtl/prd_ctrl_encode.sv
module prd_ctrl_encode #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned WIN_BITS  = 16,
    parameter int unsigned ALT_SHIFT = 2
) (
    input  logic [WIN_BITS:0]   bytes,
    input  logic                alt_fmt,
    input  logic                is_end,
    output logic [WORD_W-1:0]   ctrl
);
    localparam int unsigned END_BIT = WORD_W - 1;

    logic [WIN_BITS-1:0] quads_m1;

    always_comb begin
        quads_m1 = WIN_BITS'(bytes >> ALT_SHIFT) - WIN_BITS'(1);
        ctrl     = '0;
        if (alt_fmt) begin
            ctrl[WORD_W-1 -: WIN_BITS] = quads_m1;
        end else begin
            ctrl[WIN_BITS-1:0] = bytes[WIN_BITS-1:0];
            ctrl[END_BIT]      = is_end;
        end
    end

endmodule

// File: rtl/prd_align_check.sv
module prd_align_check #(
    parameter int unsigned STD_LSBS = 1,
    parameter int unsigned ALT_LSBS = 2
) (
    input  logic [ALT_LSBS-1:0] addr_lsb,
    input  logic [ALT_LSBS-1:0] len_lsb,
    input  logic                alt_fmt,
    output logic                misaligned
);
    logic std_bad;
    logic alt_bad;

    always_comb begin
        std_bad    = (|addr_lsb[STD_LSBS-1:0]) | (|len_lsb[STD_LSBS-1:0]);
        alt_bad    = (|addr_lsb) | (|len_lsb);
        misaligned = alt_fmt ? alt_bad : std_bad;
    end

endmodule

// File: rtl/prd_table_gen.sv
module prd_table_gen
    import prd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 32,
    parameter int unsigned WIN_BITS    = 16,
    parameter int unsigned MAX_ENTRIES = 256,
    parameter int unsigned STD_LSBS    = 1,
    parameter int unsigned ALT_LSBS    = 2,
    localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_alt_mode,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              seg_last,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [ADDR_W-1:0] word_data,
    output logic              word_last,
    output logic              tbl_done,
    output logic              tbl_fallback,
    output logic              tbl_overflow,
    output logic              tbl_misalign,
    output logic [CNT_W-1:0]  tbl_entries
);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_ENTRIES);

    prd_state_e state_q, state_d;

    logic [ADDR_W-1:0]   cur_addr_q;
    logic [LEN_W-1:0]    cur_len_q;
    logic                cur_last_q;
    logic                alt_q;
    logic                started_q;
    logic                pend_valid_q;
    logic [ADDR_W-1:0]   pend_addr_q;
    logic [WIN_BITS:0]   pend_len_q;
    logic [ADDR_W-1:0]   out_addr_q;
    logic [ADDR_W-1:0]   out_ctrl_q;
    logic                out_final_q;
    logic [CNT_W-1:0]    ent_cnt_q;
    logic                err_ovf_q;
    logic                err_align_q;

    logic                seg_fire;
    logic                mode_now;
    logic                seg_bad;
    logic [WIN_BITS:0]   chunk;
    logic [ADDR_W-1:0]   enc_ctrl;
    logic                cur_empty;
    logic                at_limit;

    assign seg_fire  = seg_valid && seg_ready;
    assign mode_now  = started_q ? alt_q : cfg_alt_mode;
    assign cur_empty = (cur_len_q == '0);
    assign at_limit  = (ent_cnt_q == CNT_LIMIT);

    prd_align_check #(
        .STD_LSBS (STD_LSBS),
        .ALT_LSBS (ALT_LSBS)
    ) u_align (
        .addr_lsb   (seg_addr[ALT_LSBS-1:0]),
        .len_lsb    (seg_len[ALT_LSBS-1:0]),
        .alt_fmt    (mode_now),
        .misaligned (seg_bad)
    );

    prd_chunk_calc #(
        .LEN_W    (LEN_W),
        .WIN_BITS (WIN_BITS)
    ) u_chunk (
        .addr_lo (cur_addr_q[WIN_BITS-1:0]),
        .remain  (cur_len_q),
        .alt_fmt (alt_q),
        .chunk   (chunk)
    );

    prd_ctrl_encode #(
        .WORD_W   (ADDR_W),
        .WIN_BITS (WIN_BITS)
    ) u_enc (
        .bytes   (pend_len_q),
        .alt_fmt (alt_q),
        .is_end  (cur_empty),
        .ctrl    (enc_ctrl)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                if (seg_fire) begin
                    if (seg_bad) begin
                        state_d = seg_last ? ST_REPORT : ST_DRAIN;
                    end else begin
                        state_d = ST_CHUNK;
                    end
                end
            end
            ST_CHUNK: begin
                if (cur_empty) begin
                    if (!cur_last_q) begin
                        state_d = ST_FETCH;
                    end else if (pend_valid_q) begin
                        state_d = ST_EMIT_ADDR;
                    end else begin
                        state_d = ST_REPORT;
                    end
                end else if (at_limit) begin
                    state_d = cur_last_q ? ST_REPORT : ST_DRAIN;
                end else if (pend_valid_q) begin
                    state_d = ST_EMIT_ADDR;
                end
            end
            ST_EMIT_ADDR: begin
                if (word_ready) begin
                    state_d = ST_EMIT_CTRL;
                end
            end
            ST_EMIT_CTRL: begin
                if (word_ready) begin
                    state_d = out_final_q ? ST_REPORT : ST_CHUNK;
                end
            end
            ST_DRAIN: begin
                if (seg_fire && seg_last) begin
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                state_d = ST_FETCH;
            end
            default: begin
                state_d = ST_FETCH;
            end
        endcase
    end

    // Outputs
    always_comb begin
        seg_ready    = (state_q == ST_FETCH) || (state_q == ST_DRAIN);
        word_valid   = (state_q == ST_EMIT_ADDR) || (state_q == ST_EMIT_CTRL);
        word_data    = (state_q == ST_EMIT_CTRL) ? out_ctrl_q : out_addr_q;
        word_last    = (state_q == ST_EMIT_CTRL) && out_final_q;
        tbl_done     = (state_q == ST_REPORT);
        tbl_overflow = tbl_done && err_ovf_q;
        tbl_misalign = tbl_done && err_align_q;
        tbl_fallback = tbl_done && (err_ovf_q || err_align_q || (ent_cnt_q == '0));
        tbl_entries  = tbl_done ? ent_cnt_q : '0;
    end

    // Segment walk, held-back entry and output word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q   <= '0;
            cur_len_q    <= '0;
            cur_last_q   <= 1'b0;
            alt_q        <= 1'b0;
            started_q    <= 1'b0;
            pend_valid_q <= 1'b0;
            pend_addr_q  <= '0;
            pend_len_q   <= '0;
            out_addr_q   <= '0;
            out_ctrl_q   <= '0;
            out_final_q  <= 1'b0;
            ent_cnt_q    <= '0;
            err_ovf_q    <= 1'b0;
            err_align_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (seg_fire) begin
                        cur_addr_q <= seg_addr;
                        cur_len_q  <= seg_len;
                        cur_last_q <= seg_last;
                        started_q  <= 1'b1;
                        if (!started_q) begin
                            alt_q <= cfg_alt_mode;
                        end
                        if (seg_bad) begin
                            err_align_q  <= 1'b1;
                            pend_valid_q <= 1'b0;
                        end
                    end
                end
                ST_CHUNK: begin
                    if (cur_empty) begin
                        if (cur_last_q && pend_valid_q) begin
                            out_addr_q   <= pend_addr_q;
                            out_ctrl_q   <= enc_ctrl;
                            out_final_q  <= 1'b1;
                            pend_valid_q <= 1'b0;
                        end
                    end else if (at_limit) begin
                        err_ovf_q    <= 1'b1;
                        pend_valid_q <= 1'b0;
                    end else begin
                        if (pend_valid_q) begin
                            out_addr_q  <= pend_addr_q;
                            out_ctrl_q  <= enc_ctrl;
                            out_final_q <= 1'b0;
                        end
                        pend_valid_q <= 1'b1;
                        pend_addr_q  <= cur_addr_q;
                        pend_len_q   <= chunk;
                        cur_addr_q   <= cur_addr_q + ADDR_W'(chunk);
                        cur_len_q    <= cur_len_q - LEN_W'(chunk);
                        ent_cnt_q    <= ent_cnt_q + CNT_W'(1);
                    end
                end
                ST_REPORT: begin
                    started_q    <= 1'b0;
                    pend_valid_q <= 1'b0;
                    out_final_q  <= 1'b0;
                    ent_cnt_q    <= '0;
                    err_ovf_q    <= 1'b0;
                    err_align_q  <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    // R1: a formed entry is non-empty and stays inside its 64 KiB window
    a_r1_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_q |-> ((pend_len_q != '0) &&
            (({2'b00, pend_addr_q[WIN_BITS-1:0]} + {1'b0, pend_len_q})
              <= {2'b01, {WIN_BITS{1'b0}}})));

    // R3: in standard format no single entry carries a whole window
    a_r3_no_full_std: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid_q && !alt_q) |-> (pend_len_q[WIN_BITS] == 1'b0));

    // R4: the entry counter never runs past the table limit
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ent_cnt_q <= CNT_LIMIT);

    // R5: the final control word is followed directly by the done pulse
    a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && word_last) |=> tbl_done);

    // R6: alternate format keeps the low half of the control word clear
    a_r6_alt_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_last && alt_q) |-> (word_data[WIN_BITS-1:0] == '0));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_done |=> !tbl_done);

    // R11: a stalled word is held unchanged
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=>
            (word_valid && $stable(word_data) && $stable(word_last)));

endmodule

// File: tb/prd_table_gen_test.sv
module prd_table_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXE       = 256;
    localparam int CW         = $clog2(MAXE + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_alt_mode = 1'b0;
    logic          seg_valid = 1'b0;
    logic          seg_ready;
    logic [31:0]   seg_addr = '0;
    logic [31:0]   seg_len = '0;
    logic          seg_last = 1'b0;
    logic          word_valid;
    logic          word_ready = 1'b1;
    logic [31:0]   word_data;
    logic          word_last;
    logic          tbl_done;
    logic          tbl_fallback;
    logic          tbl_overflow;
    logic          tbl_misalign;
    logic [CW-1:0] tbl_entries;

    int n_tests = 0;
    int n_fail  = 0;
    bit rdy_random = 1'b0;

    logic [31:0] exp_word[$];
    bit          exp_last[$];
    string       exp_tag[$];
    bit          st_fb[$];
    bit          st_ovf[$];
    bit          st_mis[$];
    int          st_cnt[$];
    string       st_tag[$];
    logic [31:0] qa[$];
    logic [31:0] ql[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prd_table_gen #(.MAX_ENTRIES(MAXE)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_alt_mode (cfg_alt_mode),
        .seg_valid    (seg_valid),
        .seg_ready    (seg_ready),
        .seg_addr     (seg_addr),
        .seg_len      (seg_len),
        .seg_last     (seg_last),
        .word_valid   (word_valid),
        .word_ready   (word_ready),
        .word_data    (word_data),
        .word_last    (word_last),
        .tbl_done     (tbl_done),
        .tbl_fallback (tbl_fallback),
        .tbl_overflow (tbl_overflow),
        .tbl_misalign (tbl_misalign),
        .tbl_entries  (tbl_entries)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Per-clock comparison against the expected stream
    always @(negedge clk) begin
        if (rst_n) begin
            word_ready = rdy_random ? ($urandom_range(0, 3) != 0) : 1'b1;
            if (word_valid && word_ready) begin
                if (exp_word.size() == 0) begin
                    chk("R5", "unexpected word", word_data, 32'hxxxxxxxx);
                end else begin
                    chk(exp_tag[0], "word", word_data, exp_word[0]);
                    chk(exp_tag[0], "word_last", 32'(word_last), 32'(exp_last[0]));
                    void'(exp_word.pop_front());
                    void'(exp_last.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            if (tbl_done) begin
                if (st_fb.size() == 0) begin
                    chk("R10", "unexpected done", 32'd1, 32'd0);
                end else begin
                    chk("R5", "words left at done", 32'(exp_word.size()), 32'd0);
                    chk(st_tag[0], "fallback", 32'(tbl_fallback), 32'(st_fb[0]));
                    chk(st_tag[0], "overflow", 32'(tbl_overflow), 32'(st_ovf[0]));
                    chk(st_tag[0], "misalign", 32'(tbl_misalign), 32'(st_mis[0]));
                    chk("R10", "entries", 32'(tbl_entries), 32'(st_cnt[0]));
                    void'(st_fb.pop_front());
                    void'(st_ovf.pop_front());
                    void'(st_mis.pop_front());
                    void'(st_cnt.pop_front());
                    void'(st_tag.pop_front());
                end
            end
        end
    end

    task automatic add_seg(input logic [31:0] a, input logic [31:0] l);
        qa.push_back(a);
        ql.push_back(l);
    endtask

    task automatic send_seg(input logic [31:0] a, input logic [31:0] l, input bit last);
        seg_addr  = a;
        seg_len   = l;
        seg_last  = last;
        seg_valid = 1'b1;
        while (!seg_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    // Behavioural model of one table, then stimulus
    task automatic run_table(input string tag, input bit alt);
        logic [31:0] ea[$];
        logic [31:0] el[$];
        bit ovf = 1'b0;
        bit mis = 1'b0;
        bit fail;
        int n = 0;
        int sendn;
        for (int i = 0; i < qa.size(); i++) begin
            logic [31:0] a;
            logic [31:0] l;
            a = qa[i];
            l = ql[i];
            if (ovf || mis) break;
            if (alt ? (((a | l) & 32'd3) != 0) : (((a | l) & 32'd1) != 0)) begin
                mis = 1'b1;
                break;
            end
            while (l != 0) begin
                longint b;
                b = 64'h10000 - longint'(a & 32'hffff);
                if (b > longint'(l)) b = longint'(l);
                if (!alt && b == 64'h10000) b = 64'h8000;
                if (n == MAXE) begin
                    ovf = 1'b1;
                    break;
                end
                ea.push_back(a);
                el.push_back(32'(b));
                n++;
                a = a + 32'(b);
                l = l - 32'(b);
            end
        end
        fail  = ovf || mis || (n == 0);
        sendn = fail ? ((n > 0) ? n - 1 : 0) : n;
        for (int k = 0; k < sendn; k++) begin
            logic [31:0] c;
            bit fin;
            fin = !fail && (k == n - 1);
            if (alt) c = (((el[k] >> 2) - 32'd1) & 32'hffff) << 16;
            else     c = (el[k] & 32'hffff) | (fin ? 32'h8000_0000 : 32'h0);
            exp_word.push_back(ea[k]); exp_last.push_back(1'b0); exp_tag.push_back(tag);
            exp_word.push_back(c);     exp_last.push_back(fin);  exp_tag.push_back(tag);
        end
        st_fb.push_back(fail);
        st_ovf.push_back(ovf);
        st_mis.push_back(mis);
        st_cnt.push_back(n);
        st_tag.push_back(tag);
        cfg_alt_mode = alt;
        for (int i = 0; i < qa.size(); i++) begin
            send_seg(qa[i], ql[i], i == qa.size() - 1);
        end
        while (st_fb.size() != 0) @(negedge clk);
        qa.delete();
        ql.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "seg_ready in reset", 32'(seg_ready), 32'd1);
        chk("R12", "word_valid in reset", 32'(word_valid), 32'd0);
        chk("R12", "tbl_done in reset", 32'(tbl_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R5: one small entry carrying the end bit
        add_seg(32'h0000_1000, 32'h200);
        run_table("R2", 1'b0);

        // R1: segment straddling a window edge
        add_seg(32'h0001_FF00, 32'h300);
        run_table("R1", 1'b0);

        // R3: whole window split into two halves
        add_seg(32'h0003_0000, 32'h1_0000);
        run_table("R3", 1'b0);

        // R8: zero-length segments, including a zero-length last one
        add_seg(32'h0000_6000, 32'h40);
        add_seg(32'h0000_7000, 32'h0);
        add_seg(32'h0000_8000, 32'h80);
        add_seg(32'h0000_9000, 32'h0);
        run_table("R8", 1'b0);

        // R6: alternate encoding across a window edge, then a whole window
        add_seg(32'h4000_FFF0, 32'h20);
        run_table("R6", 1'b1);
        add_seg(32'h0005_0000, 32'h1_0000);
        run_table("R6", 1'b1);

        // R7: nothing to describe
        add_seg(32'h0000_1234, 32'h0);
        run_table("R7", 1'b0);

        // R9: odd address in standard mode, then drained segment
        add_seg(32'h0000_2000, 32'h100);
        add_seg(32'h0000_2100, 32'h100);
        add_seg(32'h0000_3001, 32'h10);
        add_seg(32'h0000_4000, 32'h20);
        run_table("R9", 1'b0);

        // R9: length not a multiple of four in alternate mode
        add_seg(32'h0000_0100, 32'h10);
        add_seg(32'h0000_0200, 32'h6);
        run_table("R9", 1'b1);

        // R4: exactly the limit succeeds
        add_seg(32'h0000_0000, 32'h80_0000);
        run_table("R4", 1'b0);

        // R4: one window more overflows; trailing segment drained
        add_seg(32'h0000_0000, 32'h81_0000);
        add_seg(32'h0090_0000, 32'h10);
        run_table("R4", 1'b0);

        // R11: random back-pressure over several cuts
        rdy_random = 1'b1;
        add_seg(32'h000A_F000, 32'h2_3000);
        add_seg(32'h0010_0010, 32'h30);
        run_table("R11", 1'b0);
        add_seg(32'h0020_FFF8, 32'h18);
        run_table("R11", 1'b1);
        rdy_random = 1'b0;

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule